// File: doc/BRIEF.md
# Serial NOR Flash Command and Status Unit

This block is the target-side front end of a serial NOR flash device, modelled at byte level. A host exchanges one byte per transfer while chip select is low. Each transfer is marked by a one-cycle valid strobe. The unit decodes the opcode in the first byte of each command and collects any address bytes. It then moves data to or from a small internal memory array. The reply for the next byte slot appears on `tx_byte` in the cycle after each accepted byte.

The unit keeps a status byte. Bit 1 of that byte is a write-enable latch, and every command that modifies the array or the status byte is gated by it. Bit 7 is a status-write lock that works together with the external active-low write-protect input.

The unit also tracks whether addressed commands take three or four address bytes. It returns a configurable three-byte identification code. It supports a two-step reset sequence. Several commands may be chained inside one chip-select window. A read or a program, however, runs until chip select rises.

Top module: `nor_cmd_unit`

## Requirements
- R1: After reset the array reads 0xFF at every byte, the status byte is 0x00, three-byte addressing is selected, and `tx_byte` is 0xFF.
- R2: Opcode 0x9F makes `tx_byte` show the identification code one byte per slot, most significant byte first (0x20, 0xBA, 0x19 by default). After the third reply byte has been clocked, `tx_byte` returns to 0xFF and the next byte is decoded as an opcode.
- R3: Opcode 0x06 sets status bit 1 and opcode 0x04 clears it. Opcode 0x05 puts the status byte on `tx_byte` for the next slot; the byte after that is decoded as a new opcode. This allows several commands inside one chip-select window.
- R4: Opcode 0x03 takes the address most significant byte first. After the last address byte, `tx_byte` shows the byte at that address. Each further byte advances the address by one, across page boundaries, until chip select rises.
- R5: Opcode 0x02 plus address programs each following data byte as a bitwise AND with the stored byte. The address wraps within its 256-byte page. Programming takes place only if status bit 1 was set when the last address byte arrived, and in that case bit 1 clears when chip select rises.
- R6: Opcode 0xD8 plus address sets every byte of the addressed 512-byte sector to 0xFF, and leaves other sectors untouched. Opcode 0xC7 sets the whole array to 0xFF. Both act only while status bit 1 is set, and both clear it.
- R7: Opcode 0x01 followed by one data byte copies data bits 7..2 into status bits 7..2 when status bit 1 is set, and it clears bit 1 in either case. Without bit 1 set, the status byte is unchanged. Status bit 0 always reads 0.
- R8: While `wp_n` is low and status bit 7 is 1, a status write leaves status bits 7..2 unchanged. With `wp_n` high, or with bit 7 at 0, the write takes effect.
- R9: After opcode 0xB7, addressed commands take four address bytes. While only three have arrived, `tx_byte` stays 0xFF.
- R10: Opcode 0x99 clears status bit 1 and restores three-byte addressing, but only when the opcode decoded just before it was 0x66. Otherwise 0x99 has no effect.
- R11: Bytes strobed while `cs_n` is high are ignored, and `tx_byte` is 0xFF in the cycle after any cycle with `cs_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; high ends the current command |
| wp_n | input | 1 | Write protect, active low |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Byte received from the host |
| tx_byte | output | 8 | Reply byte for the next transfer slot |

## Verification
The checker assumes that `rx_valid` pulses for one cycle per byte and that `wp_n` changes only between transfers. The bench follows this: it raises the strobe for exactly one clock with `cs_n` low, and it changes `wp_n` only while no byte is in flight. It also separates each chip-select window with at least one full cycle of `cs_n` high. The protection property relies on that cycle, because that is when the latch clears after a program.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
    localparam logic [7:0] OP_IDENT  = 8'h9F;
    localparam logic [7:0] OP_RDSTAT = 8'h05;
    localparam logic [7:0] OP_WRDIS  = 8'h04;
    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_WRSTAT = 8'h01;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_SECERA = 8'hD8;
    localparam logic [7:0] OP_ALLERA = 8'hC7;
    localparam logic [7:0] OP_ADDR4  = 8'hB7;
    localparam logic [7:0] OP_RSTARM = 8'h66;
    localparam logic [7:0] OP_RSTGO  = 8'h99;

    typedef enum logic [2:0] {
        PH_OPCODE, PH_ADDR, PH_RDATA, PH_PDATA, PH_WSTAT, PH_RSTAT, PH_IDENT
    } phase_e;

    typedef enum logic [1:0] {K_READ, K_PROG, K_ERASE} kind_e;
endpackage

// File: rtl/nor_status_reg.sv
module nor_status_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wp_n,
    input  logic       wel_set,
    input  logic       wel_clr,
    input  logic       sr_wr,
    input  logic [5:0] sr_data,
    output logic [7:0] status
);
    typedef struct packed {
        logic [5:0] bits;
        logic       wel;
    } sreg_t;

    sreg_t sr_d, sr_q;
    logic  locked;

    always_comb begin
        sr_d   = sr_q;
        locked = !wp_n && sr_q.bits[5];
        if (sr_wr && sr_q.wel && !locked) begin
            sr_d.bits = sr_data;
        end
        if (wel_set) begin
            sr_d.wel = 1'b1;
        end
        if (wel_clr) begin
            sr_d.wel = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign status = {sr_q.bits, sr_q.wel, 1'b0};
endmodule

// File: rtl/nor_mem_array.sv
module nor_mem_array #(
    parameter int MEM_BYTES    = 1024,
    parameter int SECTOR_BYTES = 512,
    localparam int IW = $clog2(MEM_BYTES),
    localparam int SW = $clog2(SECTOR_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_data,
    input  logic          prog_en,
    input  logic [IW-1:0] prog_idx,
    input  logic [7:0]    prog_data,
    input  logic          sec_erase,
    input  logic [IW-1:0] sec_idx,
    input  logic          bulk_erase
);
    logic [7:0] mem_d [MEM_BYTES];
    logic [7:0] mem_q [MEM_BYTES];

    always_comb begin
        for (int i = 0; i < MEM_BYTES; i++) begin
            mem_d[i] = mem_q[i];
            if (bulk_erase || (sec_erase && ((IW'(i) >> SW) == (sec_idx >> SW)))) begin
                mem_d[i] = 8'hFF;
            end
        end
        if (prog_en) begin
            mem_d[prog_idx] = mem_q[prog_idx] & prog_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) begin
                mem_q[i] <= 8'hFF;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/nor_cmd_unit.sv
module nor_cmd_unit
    import nor_cmd_pkg::*;
#(
    parameter int          MEM_BYTES    = 1024,
    parameter int          SECTOR_BYTES = 512,
    parameter int          PAGE_BYTES   = 256,
    parameter logic [23:0] ID_CODE      = 24'h20BA19
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       wp_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    output logic [7:0] tx_byte
);
    localparam int IW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);

    typedef struct packed {
        phase_e      phase;
        kind_e       kind;
        logic [31:0] addr;
        logic [1:0]  cnt;
        logic        four_b;
        logic        armed;
        logic        pp_live;
        logic [7:0]  tx;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic [7:0]    status;
    logic          wel;
    logic          wel_set, wel_clr, sr_wr;
    logic          prog_en, sec_erase, bulk_erase;
    logic [IW-1:0] rd_idx;
    logic [7:0]    rd_data;
    logic [31:0]   addr_sh, addr_inc;
    logic [PW-1:0] pg_next;
    logic          last_addr;
    logic          op_slot, wsr_slot;

    assign wel      = status[1];
    assign op_slot  = (ctl_q.phase == PH_OPCODE);
    assign wsr_slot = (ctl_q.phase == PH_WSTAT);

    always_comb begin
        ctl_d      = ctl_q;
        wel_set    = 1'b0;
        wel_clr    = 1'b0;
        sr_wr      = 1'b0;
        prog_en    = 1'b0;
        sec_erase  = 1'b0;
        bulk_erase = 1'b0;
        addr_sh    = {ctl_q.addr[23:0], rx_byte};
        addr_inc   = ctl_q.addr + 32'd1;
        pg_next    = ctl_q.addr[PW-1:0] + PW'(1);
        last_addr  = (ctl_q.cnt == (ctl_q.four_b ? 2'd3 : 2'd2));
        rd_idx     = (ctl_q.phase == PH_ADDR) ? addr_sh[IW-1:0] : addr_inc[IW-1:0];

        if (cs_n) begin
            ctl_d.phase   = PH_OPCODE;
            ctl_d.cnt     = 2'd0;
            ctl_d.tx      = 8'hFF;
            ctl_d.pp_live = 1'b0;
            wel_clr       = ctl_q.pp_live;
        end else if (rx_valid) begin
            case (ctl_q.phase)
                PH_OPCODE: begin
                    ctl_d.tx    = 8'hFF;
                    ctl_d.cnt   = 2'd0;
                    ctl_d.addr  = '0;
                    ctl_d.armed = (rx_byte == OP_RSTARM);
                    case (rx_byte)
                        OP_IDENT: begin
                            ctl_d.phase = PH_IDENT;
                            ctl_d.tx    = ID_CODE[23:16];
                        end
                        OP_RDSTAT: begin
                            ctl_d.phase = PH_RSTAT;
                            ctl_d.tx    = status;
                        end
                        OP_WRDIS:  wel_clr = 1'b1;
                        OP_WREN:   wel_set = 1'b1;
                        OP_WRSTAT: ctl_d.phase = PH_WSTAT;
                        OP_READ: begin
                            ctl_d.phase = PH_ADDR;
                            ctl_d.kind  = K_READ;
                        end
                        OP_PROG: begin
                            ctl_d.phase = PH_ADDR;
                            ctl_d.kind  = K_PROG;
                        end
                        OP_SECERA: begin
                            ctl_d.phase = PH_ADDR;
                            ctl_d.kind  = K_ERASE;
                        end
                        OP_ALLERA: begin
                            bulk_erase = wel;
                            wel_clr    = wel;
                        end
                        OP_ADDR4: ctl_d.four_b = 1'b1;
                        OP_RSTGO: begin
                            if (ctl_q.armed) begin
                                wel_clr      = 1'b1;
                                ctl_d.four_b = 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end
                PH_ADDR: begin
                    ctl_d.addr = addr_sh;
                    ctl_d.cnt  = ctl_q.cnt + 2'd1;
                    if (last_addr) begin
                        ctl_d.cnt = 2'd0;
                        case (ctl_q.kind)
                            K_READ: begin
                                ctl_d.phase = PH_RDATA;
                                ctl_d.tx    = rd_data;
                            end
                            K_PROG: begin
                                ctl_d.phase   = PH_PDATA;
                                ctl_d.pp_live = wel;
                            end
                            default: begin
                                ctl_d.phase = PH_OPCODE;
                                sec_erase   = wel;
                                wel_clr     = wel;
                            end
                        endcase
                    end
                end
                PH_RDATA: begin
                    ctl_d.addr = addr_inc;
                    ctl_d.tx   = rd_data;
                end
                PH_PDATA: begin
                    prog_en    = ctl_q.pp_live;
                    ctl_d.addr = {ctl_q.addr[31:PW], pg_next};
                end
                PH_WSTAT: begin
                    sr_wr       = 1'b1;
                    wel_clr     = wel;
                    ctl_d.phase = PH_OPCODE;
                end
                PH_RSTAT: begin
                    ctl_d.phase = PH_OPCODE;
                    ctl_d.tx    = 8'hFF;
                end
                PH_IDENT: begin
                    if (ctl_q.cnt == 2'd2) begin
                        ctl_d.phase = PH_OPCODE;
                        ctl_d.cnt   = 2'd0;
                        ctl_d.tx    = 8'hFF;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + 2'd1;
                        ctl_d.tx  = (ctl_q.cnt == 2'd0) ? ID_CODE[15:8] : ID_CODE[7:0];
                    end
                end
                default: ctl_d.phase = PH_OPCODE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.phase <= PH_OPCODE;
            ctl_q.kind  <= K_READ;
            ctl_q.tx    <= 8'hFF;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign tx_byte = ctl_q.tx;

    nor_status_reg i_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .wp_n    (wp_n),
        .wel_set (wel_set),
        .wel_clr (wel_clr),
        .sr_wr   (sr_wr),
        .sr_data (rx_byte[7:2]),
        .status  (status)
    );

    nor_mem_array #(
        .MEM_BYTES    (MEM_BYTES),
        .SECTOR_BYTES (SECTOR_BYTES)
    ) i_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .prog_en    (prog_en),
        .prog_idx   (ctl_q.addr[IW-1:0]),
        .prog_data  (rx_byte),
        .sec_erase  (sec_erase),
        .sec_idx    (addr_sh[IW-1:0]),
        .bulk_erase (bulk_erase)
    );
endmodule

// File: rtl/nor_cmd_unit_chk.sv
module nor_cmd_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       wp_n,
    input logic       rx_valid,
    input logic [7:0] rx_byte,
    input logic [7:0] tx_byte,
    input logic [7:0] status,
    input logic       op_slot,
    input logic       wsr_slot
);
    // R3
    wren_sets_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && rx_valid && op_slot && rx_byte == 8'h06) |=> status[1]);

    // R3
    wrdis_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && rx_valid && op_slot && rx_byte == 8'h04) |=> !status[1]);

    // R8
    locked_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && rx_valid && wsr_slot && !wp_n && status[7])
        |=> (status[7:2] == $past(status[7:2])));

    // R6
    bulk_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && rx_valid && op_slot && rx_byte == 8'hC7) |=> !status[1]);

    // R11
    idle_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (tx_byte == 8'hFF));

    // R7
    stat_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && rx_valid && wsr_slot) |=> !status[0]);
endmodule

bind nor_cmd_unit nor_cmd_unit_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .wp_n     (wp_n),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .tx_byte  (tx_byte),
    .status   (status),
    .op_slot  (op_slot),
    .wsr_slot (wsr_slot)
);

// File: tb/test_nor_cmd_unit.sv
`timescale 1ns/1ps
module test_nor_cmd_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       wp_n = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic [7:0] tx_byte;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    nor_cmd_unit i_nor_cmd_unit (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_byte(tx_byte)
    );

    // vector: {end_cs, check, byte_in, expected_tx}
    localparam int NV = 59;
    localparam logic [17:0] VECS [NV] = '{
        // R2 identification
        {1'b0,1'b1,8'h9F,8'h20}, {1'b0,1'b1,8'h00,8'hBA}, {1'b0,1'b1,8'h00,8'h19},
        {1'b1,1'b1,8'h00,8'hFF},
        // R3 status and latch, chained commands
        {1'b0,1'b1,8'h05,8'h00}, {1'b1,1'b0,8'h00,8'h00},
        {1'b0,1'b0,8'h06,8'h00}, {1'b0,1'b1,8'h05,8'h02}, {1'b0,1'b0,8'h00,8'h00},
        {1'b0,1'b0,8'h04,8'h00}, {1'b0,1'b1,8'h05,8'h00}, {1'b1,1'b0,8'h00,8'h00},
        // R4 read of erased location 0x000010
        {1'b0,1'b0,8'h03,8'h00}, {1'b0,1'b0,8'h00,8'h00}, {1'b0,1'b0,8'h00,8'h00},
        {1'b0,1'b1,8'h10,8'hFF}, {1'b1,1'b1,8'h00,8'hFF},
        // R5 program at 0x0001FE with wrap to 0x000100
        {1'b0,1'b0,8'h06,8'h00}, {1'b0,1'b0,8'h02,8'h00}, {1'b0,1'b0,8'h00,8'h00},
        {1'b0,1'b0,8'h01,8'h00}, {1'b0,1'b0,8'hFE,8'h00}, {1'b0,1'b0,8'hA5,8'h00},
        {1'b0,1'b0,8'h3C,8'h00}, {1'b1,1'b0,8'h77,8'h00},
        // R5 latch cleared by chip-select rise
        {1'b0,1'b1,8'h05,8'h00}, {1'b1,1'b0,8'h00,8'h00},
        // R4 streaming read across a page boundary
        {1'b0,1'b0,8'h03,8'h00}, {1'b0,1'b0,8'h00,8'h00}, {1'b0,1'b0,8'h01,8'h00},
        {1'b0,1'b1,8'hFE,8'hA5}, {1'b0,1'b1,8'h00,8'h3C}, {1'b1,1'b1,8'h00,8'hFF},
        // R5 wrapped byte landed at 0x000100
        {1'b0,1'b0,8'h03,8'h00}, {1'b0,1'b0,8'h00,8'h00}, {1'b0,1'b0,8'h01,8'h00},
        {1'b0,1'b1,8'h00,8'h77}, {1'b1,1'b0,8'h00,8'h00},
        // R5 AND with existing contents
        {1'b0,1'b0,8'h06,8'h00}, {1'b0,1'b0,8'h02,8'h00}, {1'b0,1'b0,8'h00,8'h00},
        {1'b0,1'b0,8'h01,8'h00}, {1'b0,1'b0,8'hFE,8'h00}, {1'b1,1'b0,8'h0F,8'h00},
        {1'b0,1'b0,8'h03,8'h00}, {1'b0,1'b0,8'h00,8'h00}, {1'b0,1'b0,8'h01,8'h00},
        {1'b0,1'b1,8'hFE,8'h05}, {1'b1,1'b0,8'h00,8'h00},
        // R5 program without latch is ignored
        {1'b0,1'b0,8'h02,8'h00}, {1'b0,1'b0,8'h00,8'h00}, {1'b0,1'b0,8'h01,8'h00},
        {1'b0,1'b0,8'h00,8'h00}, {1'b1,1'b0,8'h00,8'h00},
        {1'b0,1'b0,8'h03,8'h00}, {1'b0,1'b0,8'h00,8'h00}, {1'b0,1'b0,8'h01,8'h00},
        {1'b0,1'b1,8'h00,8'h77}, {1'b1,1'b0,8'h00,8'h00}
    };

    task automatic compare(input logic [7:0] exp, input string tag);
        n_chk++;
        if (tx_byte !== exp) begin
            n_bad++;
            $display("FAIL %s: tx_byte actual %02h expected %02h", tag, tx_byte, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] din, input bit chk, input logic [7:0] exp,
                        input bit fin, input string tag);
        @(negedge clk);
        cs_n = 1'b0; rx_valid = 1'b1; rx_byte = din;
        @(negedge clk);
        rx_valid = 1'b0;
        if (chk) compare(exp, tag);
        if (fin) begin
            cs_n = 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic put(input logic [7:0] din);
        xfer(din, 1'b0, 8'h00, 1'b0, "");
    endtask

    task automatic stat_is(input logic [7:0] exp, input string tag);
        xfer(8'h05, 1'b1, exp, 1'b0, tag);
        xfer(8'h00, 1'b0, 8'h00, 1'b1, tag);
    endtask

    task automatic read3(input logic [23:0] a, input logic [7:0] exp, input string tag);
        put(8'h03); put(a[23:16]); put(a[15:8]);
        xfer(a[7:0], 1'b1, exp, 1'b1, tag);
    endtask

    task automatic wrstat(input logic [7:0] v);
        put(8'h06); put(8'h01);
        xfer(v, 1'b0, 8'h00, 1'b0, "");
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        compare(8'hFF, "R1 tx after reset");
        stat_is(8'h00, "R1 status after reset");

        for (int v = 0; v < NV; v++) begin
            xfer(VECS[v][15:8], VECS[v][16], VECS[v][7:0], VECS[v][17],
                 $sformatf("vector %0d", v));
        end

        // R11 bytes with cs_n high are ignored
        @(negedge clk);
        cs_n = 1'b1; rx_valid = 1'b1; rx_byte = 8'h06;
        @(negedge clk);
        rx_valid = 1'b0;
        compare(8'hFF, "R11 tx while deselected");
        stat_is(8'h00, "R11 latch untouched");

        // R7 status write, bit 0 reads 0, no effect without latch
        wrstat(8'hFF);
        stat_is(8'hFC, "R7 write status with latch");
        // R8 locked: wp_n low and bit 7 set
        wp_n = 1'b0;
        wrstat(8'h00);
        stat_is(8'hFC, "R8 locked write ignored");
        wp_n = 1'b1;
        wrstat(8'h00);
        stat_is(8'h00, "R8 unlocked by wp_n high");
        wp_n = 1'b0;
        wrstat(8'h80);
        stat_is(8'h80, "R8 writable with bit7 clear");
        wp_n = 1'b1;
        wrstat(8'h00);
        stat_is(8'h00, "R7 cleared");
        put(8'h01); xfer(8'hFC, 1'b0, 8'h00, 1'b0, "");
        stat_is(8'h00, "R7 no write without latch");

        // R6 sector erase
        put(8'h06); put(8'h02); put(8'h00); put(8'h02); put(8'h00);
        xfer(8'h12, 1'b0, 8'h00, 1'b1, "");
        put(8'h06); put(8'hD8); put(8'h00); put(8'h01); put(8'h00);
        stat_is(8'h00, "R6 erase clears latch");
        read3(24'h0001FE, 8'hFF, "R6 sector 0 erased");
        read3(24'h000200, 8'h12, "R6 sector 1 kept");
        put(8'hD8); put(8'h00); put(8'h02);
        xfer(8'h00, 1'b0, 8'h00, 1'b1, "");
        read3(24'h000200, 8'h12, "R6 erase without latch ignored");
        put(8'h06); put(8'hC7);
        stat_is(8'h00, "R6 bulk clears latch");
        read3(24'h000200, 8'hFF, "R6 bulk erased");

        // R9 four-byte addressing
        xfer(8'hB7, 1'b0, 8'h00, 1'b1, "");
        put(8'h06); put(8'h02); put(8'h00); put(8'h00); put(8'h00); put(8'h30);
        xfer(8'h5A, 1'b0, 8'h00, 1'b1, "");
        put(8'h03); put(8'h00); put(8'h00);
        xfer(8'h00, 1'b1, 8'hFF, 1'b0, "R9 no data after three bytes");
        xfer(8'h30, 1'b1, 8'h5A, 1'b1, "R9 four-byte read");

        // R10 reset sequence
        put(8'h66);
        xfer(8'h99, 1'b0, 8'h00, 1'b1, "");
        read3(24'h000030, 8'h5A, "R10 back to three-byte");
        put(8'h06); put(8'h66); put(8'h99);
        stat_is(8'h00, "R10 reset clears latch");
        put(8'h06); put(8'h99);
        stat_is(8'h02, "R10 lone reset ignored");
        put(8'h66); put(8'h06); put(8'h99);
        stat_is(8'h02, "R10 interrupted sequence ignored");
        xfer(8'h04, 1'b0, 8'h00, 1'b1, "");

        summary();
    end
endmodule